// File: doc/BRIEF.md
# Relative Timestamp Emitter

This block measures elapsed time between trace events and decides when a relative timestamp has to be sent. A power-of-four prescaler turns the clock into time ticks. A delta counter accumulates those ticks. Whenever a timestamp is emitted, the delta counter starts again from zero, so each value sent is the time since the previous one rather than an absolute time.

A timestamp is emitted for one of three reasons. A trace packet is written while the delta is non-zero. The delta counter is about to wrap. Or the trace path has been idle for a fixed number of ticks, which gives the gaps between packets a time reference. A packet formatter downstream takes the one-cycle strobe, the delta value and an overflow flag, and turns them into packets. Packet encoding and arbitration with other sources are not part of this block.

Top module: `ts_delta_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ts_emit`, `ts_ovf` and `ts_delta` are all zero.
- R2: `presc_sel` selects the tick period: 0 = every cycle, 1 = every 4 cycles, 2 = every 16 cycles, 3 = every 64 cycles. The divider starts from its boundary when `ts_en` rises.
- R3: While `ts_en` is low, no timestamp is emitted. The delta counter and the idle timer are held at zero, so after re-enabling, time is measured only from the re-enable point.
- R4: A `pkt_wr` pulse in a cycle where the delta is non-zero produces `ts_emit` one cycle later, with `ts_delta` equal to the ticks counted before that cycle and `ts_ovf` low. Every emission clears the delta counter, and a tick that falls in the emitting cycle is absorbed.
- R5: A `pkt_wr` in a cycle where the delta is zero emits nothing. The tick of that cycle is still counted.
- R6: When a tick arrives while the delta counter holds all ones, a timestamp is emitted with `ts_ovf` high and `ts_delta` all ones. This takes precedence over a packet write in the same cycle.
- R7: After IDLE_TICKS consecutive ticks with `idle` high and no `pkt_wr`, a timestamp is emitted with `ts_ovf` low. While idle continues, this repeats every IDLE_TICKS ticks.
- R8: A cycle with `idle` low restarts the idle timer from zero.
- R9: A change of `presc_sel` clears the divider in that cycle, with no tick. The next tick comes one full new period later.
- R10: `ts_emit` is a single-cycle strobe that is never high two cycles in a row. `ts_delta` is zero and non-zero exactly when `ts_emit` is low and high respectively, and `ts_ovf` is high only together with `ts_emit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ts_en | input | 1 | Timestamp enable |
| presc_sel | input | 2 | Tick prescale select (0:/1, 1:/4, 2:/16, 3:/64) |
| pkt_wr | input | 1 | One-cycle mark of a trace packet entering the FIFO |
| idle | input | 1 | Trace path idle indication |
| ts_emit | output | 1 | Timestamp emit strobe |
| ts_delta | output | DELTA_W | Ticks since the previous timestamp, valid with `ts_emit` |
| ts_ovf | output | 1 | Emission was caused by delta counter wrap |

## Verification
The bench builds the block with DELTA_W = 6 and IDLE_TICKS = 8. With these values the wrap point is 63 ticks away and the idle timeout is 8 ticks away, so overflow emission, repeated idle emission and idle-timer restart can be reached in a few hundred cycles. At the default values (21 bits, 1024 ticks) they would take millions of cycles. The prescaler keeps its fixed divide ratios, so all four selects and a mid-period select change are run at their real lengths.

// File: rtl/ts_delta_pkg.sv
package ts_delta_pkg;

   localparam int unsigned PSC_CNT_W = 6;

   typedef enum logic [1:0] {
      PSC_DIV1  = 2'd0,
      PSC_DIV4  = 2'd1,
      PSC_DIV16 = 2'd2,
      PSC_DIV64 = 2'd3
   } psc_sel_e;

   typedef enum logic [1:0] {
      TRIG_NONE = 2'd0,
      TRIG_PKT  = 2'd1,
      TRIG_IDLE = 2'd2,
      TRIG_WRAP = 2'd3
   } trig_e;

   // terminal count of the divider for a given select
   function automatic logic [PSC_CNT_W-1:0] psc_limit(input logic [1:0] sel);
      logic [PSC_CNT_W-1:0] lim;
      case (psc_sel_e'(sel))
         PSC_DIV1:  lim = PSC_CNT_W'(0);
         PSC_DIV4:  lim = PSC_CNT_W'(3);
         PSC_DIV16: lim = PSC_CNT_W'(15);
         default:   lim = PSC_CNT_W'(63);
      endcase
      return lim;
   endfunction

endpackage

// File: rtl/ts_psc_divider.sv
module ts_psc_divider
   import ts_delta_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);

   localparam int unsigned NSEL = 4;

   logic [PSC_CNT_W-1:0] div_cnt;
   logic [1:0]           sel_q;
   logic [NSEL-1:0]      hit;
   logic                 sel_chg;

   // one terminal compare per select value
   for (genvar g = 0; g < NSEL; g++) begin : g_hit
      assign hit[g] = (div_cnt == psc_limit(2'(g)));
   end

   assign sel_chg = (sel != sel_q);
   assign tick    = run && !sel_chg && hit[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         sel_q   <= 2'd0;
      end else begin
         sel_q <= sel;
         if (!run || sel_chg || tick)
            div_cnt <= '0;
         else
            div_cnt <= div_cnt + PSC_CNT_W'(1);
      end
   end

endmodule

// File: rtl/ts_delta_ctr.sv
module ts_delta_ctr #(
   parameter int unsigned DELTA_W = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic               clr,
   output logic [DELTA_W-1:0] delta,
   output logic               at_max
);

   assign at_max = &delta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         delta <= '0;
      else if (!run || clr)
         delta <= '0;
      else if (tick)
         delta <= delta + DELTA_W'(1);
   end

endmodule

// File: rtl/ts_idle_timer.sv
module ts_idle_timer #(
   parameter int unsigned IDLE_TICKS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic idle,
   input  logic pkt,
   input  logic tick,
   input  logic clr,
   output logic expire
);

   localparam int unsigned IDLE_W = (IDLE_TICKS > 2) ? $clog2(IDLE_TICKS) : 1;
   localparam logic [IDLE_W-1:0] LAST = IDLE_W'(IDLE_TICKS - 1);

   logic [IDLE_W-1:0] idle_cnt;
   logic              quiet;

   assign quiet  = run && idle && !pkt;
   assign expire = quiet && tick && (idle_cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idle_cnt <= '0;
      else if (!quiet || clr)
         idle_cnt <= '0;
      else if (tick)
         idle_cnt <= idle_cnt + IDLE_W'(1);
   end

endmodule

// File: rtl/ts_emit_stage.sv
module ts_emit_stage
   import ts_delta_pkg::*;
#(
   parameter int unsigned DELTA_W = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               tick,
   input  logic               pkt,
   input  logic               idle_expire,
   input  logic [DELTA_W-1:0] delta,
   input  logic               at_max,
   output logic               clr,
   output logic               emit_q,
   output logic [DELTA_W-1:0] delta_q,
   output logic               ovf_q
);

   trig_e trig;

   // wrap outranks a packet, a packet outranks the idle timeout
   always_comb begin
      trig = TRIG_NONE;
      if (run) begin
         if (tick && at_max)
            trig = TRIG_WRAP;
         else if (pkt && (delta != '0))
            trig = TRIG_PKT;
         else if (idle_expire)
            trig = TRIG_IDLE;
      end
   end

   assign clr = (trig != TRIG_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emit_q  <= 1'b0;
         delta_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         emit_q  <= clr;
         delta_q <= clr ? delta : '0;
         ovf_q   <= (trig == TRIG_WRAP);
      end
   end

endmodule

// File: rtl/ts_delta_gen.sv
module ts_delta_gen #(
   parameter int unsigned DELTA_W    = 21,
   parameter int unsigned IDLE_TICKS = 1024
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ts_en,
   input  logic [1:0]         presc_sel,
   input  logic               pkt_wr,
   input  logic               idle,
   output logic               ts_emit,
   output logic [DELTA_W-1:0] ts_delta,
   output logic               ts_ovf
);

   if (DELTA_W < 2) begin : g_bad_width
      $error("ts_delta_gen: DELTA_W must be at least 2");
   end
   if (IDLE_TICKS < 2) begin : g_bad_idle
      $error("ts_delta_gen: IDLE_TICKS must be at least 2");
   end
   if ($clog2(IDLE_TICKS) >= DELTA_W) begin : g_bad_ratio
      $error("ts_delta_gen: idle timeout must fit below the wrap point");
   end

   logic               tick;
   logic               clr;
   logic               at_max;
   logic               idle_expire;
   logic [DELTA_W-1:0] delta;

   ts_psc_divider u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ts_en),
      .sel   (presc_sel),
      .tick  (tick)
   );

   ts_delta_ctr #(.DELTA_W(DELTA_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ts_en),
      .tick   (tick),
      .clr    (clr),
      .delta  (delta),
      .at_max (at_max)
   );

   ts_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ts_en),
      .idle   (idle),
      .pkt    (pkt_wr),
      .tick   (tick),
      .clr    (clr),
      .expire (idle_expire)
   );

   ts_emit_stage #(.DELTA_W(DELTA_W)) u_emit (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (ts_en),
      .tick        (tick),
      .pkt         (pkt_wr),
      .idle_expire (idle_expire),
      .delta       (delta),
      .at_max      (at_max),
      .clr         (clr),
      .emit_q      (ts_emit),
      .delta_q     (ts_delta),
      .ovf_q       (ts_ovf)
   );

endmodule

// File: rtl/ts_delta_gen_chk.sv
module ts_delta_gen_chk #(
   parameter int unsigned DELTA_W = 21
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ts_en,
   input logic               ts_emit,
   input logic [DELTA_W-1:0] ts_delta,
   input logic               ts_ovf
);

   // R3
   en_gates_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_emit |-> $past(ts_en));

   // R3
   off_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_en |=> !ts_emit);

   // R6
   ovf_with_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_ovf |-> ts_emit);

   // R6
   ovf_full_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_ovf |-> (ts_delta == {DELTA_W{1'b1}}));

   // R10
   emit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_emit |=> !ts_emit);

   // R10
   emit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_emit |-> (ts_delta != '0));

   // R10
   quiet_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_emit |-> (ts_delta == '0));

endmodule

bind ts_delta_gen ts_delta_gen_chk #(.DELTA_W(DELTA_W)) u_ts_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ts_en    (ts_en),
   .ts_emit  (ts_emit),
   .ts_delta (ts_delta),
   .ts_ovf   (ts_ovf)
);

// File: tb/test_ts_delta_gen.sv
module test_ts_delta_gen;

   localparam int unsigned DW   = 6;
   localparam int unsigned IDLE = 8;
   localparam int          MAXD = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ts_en = 1'b0;
   logic [1:0]    presc_sel = 2'd0;
   logic          pkt_wr = 1'b0;
   logic          idle = 1'b0;
   logic          ts_emit;
   logic [DW-1:0] ts_delta;
   logic          ts_ovf;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   ts_delta_gen #(.DELTA_W(DW), .IDLE_TICKS(IDLE)) i_ts_delta_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .ts_en     (ts_en),
      .presc_sel (presc_sel),
      .pkt_wr    (pkt_wr),
      .idle      (idle),
      .ts_emit   (ts_emit),
      .ts_delta  (ts_delta),
      .ts_ovf    (ts_ovf)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quiesce();
      ts_en = 1'b0; pkt_wr = 1'b0; idle = 1'b0;
      cyc(2);
   endtask

   task automatic expect_emit(input string req, input int d, input bit ovf);
      check(ts_emit == 1'b1, {req, " emit"}, int'(ts_emit), 1);
      check(int'(ts_delta) == d, {req, " delta"}, int'(ts_delta), d);
      check(ts_ovf == ovf, {req, " ovf"}, int'(ts_ovf), int'(ovf));
   endtask

   // n cycles in which no emission may appear
   task automatic quiet_window(input string req, input int n);
      bit seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         cyc(1);
         if (ts_emit) seen = 1'b1;
      end
      check(!seen, {req, " no emit in window"}, int'(seen), 0);
   endtask

   task automatic t_reset();
      cyc(1);
      check(ts_emit == 1'b0 && ts_ovf == 1'b0, "R1 flags in reset", int'(ts_emit) + int'(ts_ovf), 0);
      check(ts_delta == '0, "R1 delta in reset", int'(ts_delta), 0);
      rst_n = 1'b1;
      cyc(1);
      check(ts_emit == 1'b0 && ts_delta == '0, "R1 after release", int'(ts_delta), 0);
   endtask

   task automatic t_prescale(input logic [1:0] sel, input int n, input int exp);
      quiesce();
      presc_sel = sel;
      cyc(1);
      ts_en = 1'b1;
      cyc(n);
      pkt_wr = 1'b1;
      cyc(1);
      pkt_wr = 1'b0;
      expect_emit("R2/R4 prescaled delta", exp, 1'b0);
      cyc(1);
      check(ts_emit == 1'b0 && ts_delta == '0, "R10 strobe ends", int'(ts_delta), 0);
   endtask

   task automatic t_zero_delta();
      quiesce();
      presc_sel = 2'd0;
      cyc(1);
      ts_en = 1'b1; pkt_wr = 1'b1;
      cyc(1);
      check(ts_emit == 1'b0, "R5 packet at zero delta", int'(ts_emit), 0);
      pkt_wr = 1'b0;
      cyc(5);
      pkt_wr = 1'b1;
      cyc(1);
      expect_emit("R4 packet delta", 6, 1'b0);
      cyc(1);
      check(ts_emit == 1'b0, "R5 packet right after emit", int'(ts_emit), 0);
      pkt_wr = 1'b0;
      cyc(4);
      pkt_wr = 1'b1;
      cyc(1);
      pkt_wr = 1'b0;
      expect_emit("R5 zero-delta tick still counted", 5, 1'b0);
   endtask

   task automatic t_disable();
      quiesce();
      presc_sel = 2'd0;
      cyc(1);
      ts_en = 1'b1;
      cyc(20);
      ts_en = 1'b0; pkt_wr = 1'b1;
      quiet_window("R3 packets while disabled", 5);
      pkt_wr = 1'b0;
      ts_en = 1'b1;
      cyc(3);
      pkt_wr = 1'b1;
      cyc(1);
      pkt_wr = 1'b0;
      expect_emit("R3 delta restarts at enable", 3, 1'b0);
      quiesce();
      idle = 1'b1; ts_en = 1'b1;
      cyc(5);
      ts_en = 1'b0;
      cyc(3);
      ts_en = 1'b1;
      quiet_window("R3 idle timer held at zero", 7);
      cyc(1);
      expect_emit("R3 idle after re-enable", 7, 1'b0);
   endtask

   task automatic t_idle();
      quiesce();
      presc_sel = 2'd0;
      cyc(1);
      idle = 1'b1; ts_en = 1'b1;
      quiet_window("R7 before timeout", 7);
      cyc(1);
      expect_emit("R7 first idle stamp", 7, 1'b0);
      quiet_window("R7 between stamps", 7);
      cyc(1);
      expect_emit("R7 repeated idle stamp", 7, 1'b0);
   endtask

   task automatic t_idle_restart();
      quiesce();
      presc_sel = 2'd0;
      cyc(1);
      ts_en = 1'b1; idle = 1'b1;
      cyc(5);
      idle = 1'b0;
      cyc(1);
      idle = 1'b1;
      quiet_window("R8 timer restarted", 7);
      cyc(1);
      expect_emit("R8 stamp after restart", 13, 1'b0);
   endtask

   task automatic t_wrap();
      quiesce();
      presc_sel = 2'd0;
      cyc(1);
      ts_en = 1'b1;
      quiet_window("R6 below wrap", MAXD);
      cyc(1);
      expect_emit("R6 wrap stamp", MAXD, 1'b1);
      cyc(1);
      check(ts_ovf == 1'b0 && ts_emit == 1'b0, "R6 flag clears", int'(ts_ovf), 0);
      cyc(9);
      pkt_wr = 1'b1;
      cyc(1);
      pkt_wr = 1'b0;
      expect_emit("R6 counter cleared by wrap", 10, 1'b0);
      quiesce();
      ts_en = 1'b1;
      cyc(MAXD);
      pkt_wr = 1'b1;
      cyc(1);
      pkt_wr = 1'b0;
      expect_emit("R6 wrap outranks packet", MAXD, 1'b1);
   endtask

   task automatic t_sel_change();
      quiesce();
      presc_sel = 2'd1;
      cyc(1);
      ts_en = 1'b1;
      cyc(2);
      presc_sel = 2'd2;
      cyc(1);
      cyc(15);
      pkt_wr = 1'b1;
      cyc(1);
      check(ts_emit == 1'b0, "R9 no tick before new period", int'(ts_emit), 0);
      cyc(1);
      pkt_wr = 1'b0;
      expect_emit("R9 first tick after change", 1, 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      t_reset();
      t_prescale(2'd0, 10, 10);
      t_prescale(2'd1, 40, 10);
      t_prescale(2'd2, 160, 10);
      t_prescale(2'd3, 640, 10);
      t_zero_delta();
      t_disable();
      t_idle();
      t_idle_restart();
      t_wrap();
      t_sel_change();
      quiesce();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule